// File: doc/BRIEF.md
# Cross-Domain Timer Register Bridge

This block sits between a processor bus running on a fast clock and a small timer that runs on a separate, slower clock with no fixed phase relation to it. The processor writes a compare value and a two-bit control word. Each write goes into a holding register on the processor side and is then carried into the timer domain with a toggle handshake. A per-register busy flag is readable while the transfer is in flight, and further writes to that register are dropped until it clears.

The timer is an 8-bit up-counter. Its count reaches the processor through a shadow register that is reloaded only when a rising edge of the timer clock has been seen through a synchronizer. If the timer clock stops, the shadow keeps showing the last count it took. A compare match toggles an output that belongs to the timer domain. The match is also turned into a sticky interrupt flag on the processor side, which arrives one timer cycle plus three processor cycles after the count reaches the compare value.

Top module: `async_tmr_bridge`

## Requirements
- R1: While `rst_n` is low, `cnt_rd`, `busy`, `irq_flag` and `cmp_out` are all 0. The compare register resets to 8'hFF and the control word resets to 2'b01 (running, no clear).
- R2: A write is accepted at a `cpu_clk` rising edge where `wr_en` is 1 and the addressed busy bit is 0. `wr_sel`=0 addresses the compare register and `busy[0]`; `wr_sel`=1 addresses the control word (`wr_data[1:0]`) and `busy[1]`. The addressed busy bit reads 1 from the next cycle on. The two registers are independent of each other.
- R3: A write to a register whose busy bit is 1 is dropped. The value that reaches the timer is the one accepted earlier.
- R4: An accepted value becomes active at the third rising `tmr_clk` edge after the accepting edge. The counter update at that same edge still uses the old value.
- R5: A busy bit returns to 0 at the second `cpu_clk` rising edge after the timer edge that took its value.
- R6: `cnt_rd` takes the current timer count at the third `cpu_clk` rising edge after each rising `tmr_clk` edge. At all other edges it holds its value.
- R7: While `tmr_clk` is halted, `cnt_rd` keeps the last count it captured.
- R8: At each rising `tmr_clk` edge the count increments when control bit 0 (run) is 1 and holds when it is 0. The count wraps from 255 to 0. When control bit 1 is also 1, the count goes to 0 instead at an edge where it equals the compare value.
- R9: At each rising `tmr_clk` edge where the run bit is 1 and the count equals the compare value, `cmp_out` toggles.
- R10: `irq_flag` sets at the third `cpu_clk` rising edge after the timer edge of R9. It stays set until a `cpu_clk` edge sees `irq_clr` high. If a new match arrives in the same cycle as a clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor-side clock |
| tmr_clk | input | 1 | Slow timer clock, unrelated in phase |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Register select: 0 compare, 1 control |
| wr_data | input | 8 | Write value |
| irq_clr | input | 1 | Clears the interrupt flag |
| cnt_rd | output | 8 | Shadow copy of the timer count |
| busy | output | 2 | Update-busy flags: bit 0 compare, bit 1 control |
| irq_flag | output | 1 | Sticky compare-match flag, processor domain |
| cmp_out | output | 1 | Match toggle output, timer domain |

## Verification
The timer-domain properties assume that a busy flag stays high across the timer edge that loads its value. This holds only if the timer clock is slower than the processor clock, so that the two-cycle return path has not finished. The shadow capture assumes the count is stable for several processor cycles after each timer edge. The stimulus keeps both assumptions by running the timer at a half period of 2.32 processor periods. Its edges fall on an odd offset grid, so they never coincide with a processor edge. Writes are issued only while the timer clock is running.

// File: rtl/atsync_pkg.sv
package atsync_pkg;
    localparam int CTL_W   = 2;
    localparam int CTL_RUN = 0;
    localparam int CTL_CLR = 1;
    typedef enum logic {SEL_CMP = 1'b0, SEL_CTL = 1'b1} wsel_e;
endpackage

// File: rtl/atsync_sync2.sv
module atsync_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = d;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign q = sync_q.s2;
endmodule

// File: rtl/atsync_wchan.sv
module atsync_wchan #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         cpu_clk,
    input  logic         tmr_clk,
    input  logic         rst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wr_data,
    output logic         busy,
    output logic [W-1:0] tval
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic         req;
    } cside_t;

    typedef struct packed {
        logic [W-1:0] val;
        logic         ack;
    } tside_t;

    cside_t c_d, c_q;
    tside_t t_d, t_q;
    logic   ack_c, req_t, accept, tld;

    atsync_sync2 u_ack_sync (.clk(cpu_clk), .rst_n(rst_n), .d(t_q.ack), .q(ack_c));
    atsync_sync2 u_req_sync (.clk(tmr_clk), .rst_n(rst_n), .d(c_q.req), .q(req_t));

    always_comb begin
        busy     = c_q.req ^ ack_c;
        accept   = wr_req & ~busy;
        c_d.hold = accept ? wr_data : c_q.hold;
        c_d.req  = c_q.req ^ accept;
    end

    always_comb begin
        tld     = req_t ^ t_q.ack;
        t_d.ack = req_t;
        t_d.val = tld ? c_q.hold : t_q.val;
    end

    always_ff @(posedge cpu_clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_ff @(posedge tmr_clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.val <= RST_VAL;
            t_q.ack <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign tval = t_q.val;
endmodule

// File: rtl/atsync_tcore.sv
module atsync_tcore #(
    parameter int DW = 8
) (
    input  logic          tmr_clk,
    input  logic          rst_n,
    input  logic [DW-1:0] cmp,
    input  logic          run,
    input  logic          clr_on_hit,
    output logic [DW-1:0] cnt,
    output logic          tgl
);
    localparam logic [DW-1:0] ONE = 1;

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          tgl;
    } core_t;

    core_t core_d, core_q;
    logic  hit;

    always_comb begin
        core_d = core_q;
        hit    = run && (core_q.cnt == cmp);
        if (run) core_d.cnt = (hit && clr_on_hit) ? '0 : core_q.cnt + ONE;
        core_d.tgl = core_q.tgl ^ hit;
    end

    always_ff @(posedge tmr_clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign cnt = core_q.cnt;
    assign tgl = core_q.tgl;
endmodule

// File: rtl/async_tmr_bridge.sv
module async_tmr_bridge
    import atsync_pkg::*;
#(
    parameter int                DW       = 8,
    parameter logic [DW-1:0]     CMP_RST  = '1,
    parameter logic [CTL_W-1:0]  CTRL_RST = 2'b01
) (
    input  logic          cpu_clk,
    input  logic          tmr_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          irq_clr,
    output logic [DW-1:0] cnt_rd,
    output logic [1:0]    busy,
    output logic          irq_flag,
    output logic          cmp_out
);
    typedef struct packed {
        logic          tprev;
        logic          mprev;
        logic [DW-1:0] shadow;
        logic          irq;
    } cpu_t;

    cpu_t             cpu_d, cpu_q;
    logic [DW-1:0]    cmp_t, cnt_t;
    logic [CTL_W-1:0] ctrl_t;
    logic             tgl_t, tsync, msync, tedge, evt;

    atsync_wchan #(.W(DW), .RST_VAL(CMP_RST)) u_cmp_ch (
        .cpu_clk(cpu_clk), .tmr_clk(tmr_clk), .rst_n(rst_n),
        .wr_req(wr_en && (wr_sel == SEL_CMP)), .wr_data(wr_data),
        .busy(busy[0]), .tval(cmp_t)
    );

    atsync_wchan #(.W(CTL_W), .RST_VAL(CTRL_RST)) u_ctl_ch (
        .cpu_clk(cpu_clk), .tmr_clk(tmr_clk), .rst_n(rst_n),
        .wr_req(wr_en && (wr_sel == SEL_CTL)), .wr_data(wr_data[CTL_W-1:0]),
        .busy(busy[1]), .tval(ctrl_t)
    );

    atsync_tcore #(.DW(DW)) u_core (
        .tmr_clk(tmr_clk), .rst_n(rst_n), .cmp(cmp_t),
        .run(ctrl_t[CTL_RUN]), .clr_on_hit(ctrl_t[CTL_CLR]),
        .cnt(cnt_t), .tgl(tgl_t)
    );

    atsync_sync2 u_tclk_sync (.clk(cpu_clk), .rst_n(rst_n), .d(tmr_clk), .q(tsync));
    atsync_sync2 u_hit_sync  (.clk(cpu_clk), .rst_n(rst_n), .d(tgl_t),   .q(msync));

    always_comb begin
        tedge        = tsync & ~cpu_q.tprev;
        evt          = msync ^ cpu_q.mprev;
        cpu_d.tprev  = tsync;
        cpu_d.mprev  = msync;
        cpu_d.shadow = tedge ? cnt_t : cpu_q.shadow;
        cpu_d.irq    = evt | (cpu_q.irq & ~irq_clr);
    end

    always_ff @(posedge cpu_clk or negedge rst_n) begin
        if (!rst_n) cpu_q <= '0;
        else        cpu_q <= cpu_d;
    end

    assign cnt_rd   = cpu_q.shadow;
    assign irq_flag = cpu_q.irq;
    assign cmp_out  = tgl_t;
endmodule

// File: rtl/atsync_chk.sv
module atsync_chk #(
    parameter int DW = 8
) (
    input logic          cpu_clk,
    input logic          tmr_clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          wr_sel,
    input logic          irq_clr,
    input logic [1:0]    busy,
    input logic          irq_flag,
    input logic          cmp_out,
    input logic [DW-1:0] cnt_t,
    input logic [DW-1:0] cmp_t,
    input logic [1:0]    ctrl_t
);
    assert_busy_set_R2: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        (wr_en && !wr_sel && !busy[0]) |=> busy[0]);

    assert_busy_cause_R2: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        $rose(busy[1]) |-> $past(wr_en && wr_sel));

    assert_load_pending_R4: assert property (@(posedge tmr_clk) disable iff (!rst_n)
        (cmp_t != $past(cmp_t)) |-> $past(busy[0]));

    assert_hold_stopped_R8: assert property (@(posedge tmr_clk) disable iff (!rst_n)
        !ctrl_t[0] |=> (cnt_t == $past(cnt_t)));

    assert_match_toggle_R9: assert property (@(posedge tmr_clk) disable iff (!rst_n)
        (ctrl_t[0] && (cnt_t == cmp_t)) |=> (cmp_out != $past(cmp_out)));

    assert_irq_sticky_R10: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);
endmodule

bind async_tmr_bridge atsync_chk #(.DW(DW)) u_chk (
    .cpu_clk(cpu_clk), .tmr_clk(tmr_clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .irq_clr(irq_clr),
    .busy(busy), .irq_flag(irq_flag), .cmp_out(cmp_out),
    .cnt_t(cnt_t), .cmp_t(cmp_t), .ctrl_t(ctrl_t)
);

// File: tb/sim_async_tmr_bridge.sv
module sim_async_tmr_bridge;
    localparam int CLK_PS   = 10000;
    localparam int THALF_PS = 23200;
    localparam int WDOG     = 150000;

    logic       cpu_clk = 1'b0, tmr_clk = 1'b0, rst_n = 1'b0, tmr_go = 1'b1;
    logic       wr_en = 1'b0, wr_sel = 1'b0, irq_clr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] cnt_rd;
    logic [1:0] busy;
    logic       irq_flag, cmp_out;

    int n_cmp = 0, n_bad = 0;

    async_tmr_bridge u0 (
        .cpu_clk(cpu_clk), .tmr_clk(tmr_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq_clr(irq_clr),
        .cnt_rd(cnt_rd), .busy(busy), .irq_flag(irq_flag), .cmp_out(cmp_out)
    );

    initial forever #(CLK_PS/2) cpu_clk = ~cpu_clk;

    initial begin
        #100;
        forever begin
            #(THALF_PS);
            if (tmr_go) tmr_clk = ~tmr_clk;
        end
    end

    // processor-side reference state
    logic [1:0] ebusy = 2'b00;
    logic       eirq = 1'b0, l1 = 1'b0, l2 = 1'b0, l3 = 1'b0;
    logic [7:0] eshadow = 8'h00;
    logic [7:0] acc_v [2];
    int         acc_n [2], ld_seen [2], ccd [2];
    int         hit_seen = 0, icd = 0;
    // timer-side reference state
    logic [7:0] mcnt = 8'h00, mcmp = 8'hFF;
    logic [1:0] mctl = 2'b01;
    logic       mtgl = 1'b0;
    int         tseen [2], tcd [2], ld_n [2];
    int         hit_n = 0;

    initial begin
        for (int s = 0; s < 2; s++) begin
            acc_v[s] = 8'h00; acc_n[s] = 0; ld_seen[s] = 0; ccd[s] = 0;
            tseen[s] = 0; tcd[s] = 0; ld_n[s] = 0;
        end
    end

    always @(posedge cpu_clk) begin
        if (!rst_n) begin
            ebusy = 2'b00; eirq = 1'b0; eshadow = 8'h00;
            l1 = 1'b0; l2 = 1'b0; l3 = 1'b0; hit_seen = 0; icd = 0;
            for (int s = 0; s < 2; s++) begin acc_n[s] = 0; ld_seen[s] = 0; ccd[s] = 0; end
        end else begin
            logic set;
            for (int s = 0; s < 2; s++) begin
                if (wr_en && (wr_sel == s[0]) && !ebusy[s]) begin
                    acc_n[s]++; acc_v[s] = wr_data; ebusy[s] = 1'b1;
                end
                if (ld_n[s] != ld_seen[s]) begin ld_seen[s] = ld_n[s]; ccd[s] = 2; end
                if (ccd[s] > 0) begin
                    ccd[s]--;
                    if (ccd[s] == 0) ebusy[s] = 1'b0;
                end
            end
            if (hit_n != hit_seen) begin hit_seen = hit_n; icd = 3; end
            set = 1'b0;
            if (icd > 0) begin
                icd--;
                if (icd == 0) set = 1'b1;
            end
            eirq = set | (eirq & !irq_clr);
            if (l2 && !l3) eshadow = mcnt;
            l3 = l2; l2 = l1; l1 = tmr_clk;
        end
    end

    always @(posedge tmr_clk) begin
        if (!rst_n) begin
            mcnt = 8'h00; mcmp = 8'hFF; mctl = 2'b01; mtgl = 1'b0; hit_n = 0;
            for (int s = 0; s < 2; s++) begin tseen[s] = 0; tcd[s] = 0; ld_n[s] = 0; end
        end else begin
            logic hit;
            hit = mctl[0] && (mcnt == mcmp);
            if (mctl[0]) mcnt = (hit && mctl[1]) ? 8'h00 : mcnt + 8'h01;
            if (hit) begin mtgl = ~mtgl; hit_n++; end
            for (int s = 0; s < 2; s++) begin
                if (acc_n[s] != tseen[s]) begin tseen[s] = acc_n[s]; tcd[s] = 3; end
                if (tcd[s] > 0) begin
                    tcd[s]--;
                    if (tcd[s] == 0) begin
                        if (s == 0) mcmp = acc_v[0];
                        else        mctl = acc_v[1][1:0];
                        ld_n[s]++;
                    end
                end
            end
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge cpu_clk) begin
        if (!rst_n) begin
            chk(cnt_rd, 8'h00, "R1 cnt_rd");
            chk({6'b0, busy}, 8'h00, "R1 busy");
            chk({7'b0, irq_flag}, 8'h00, "R1 irq_flag");
            chk({7'b0, cmp_out}, 8'h00, "R1 cmp_out");
        end else begin
            chk(cnt_rd, eshadow, "R6 R7 R8 R4 cnt_rd");
            chk({6'b0, busy}, {6'b0, ebusy}, "R2 R3 R5 busy");
            chk({7'b0, irq_flag}, {7'b0, eirq}, "R10 R4 R3 irq_flag");
            chk({7'b0, cmp_out}, {7'b0, mtgl}, "R9 cmp_out");
        end
    end

    task automatic wr(input logic sel, input logic [7:0] val);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge cpu_clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge cpu_clk);
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1;
        @(negedge cpu_clk);
        irq_clr = 1'b0;
    endtask

    initial begin
        idle(10);
        rst_n = 1'b1;
        idle(200);
        wr(1'b0, 8'd20);        // R2 accepted compare write
        wr(1'b0, 8'd99);        // R3 dropped while busy
        idle(1400);             // R4 R9 R10 match at 20 after wrap
        pulse_clr();            // R10 clear
        wr(1'b1, 8'h03);        // R8 clear-on-match mode
        idle(300);
        pulse_clr();
        wr(1'b0, 8'd5);         // R2 both registers in flight
        wr(1'b1, 8'h03);
        idle(250);
        tmr_go = 1'b0;          // R7 timer clock halted
        idle(60);
        tmr_go = 1'b1;
        idle(120);
        wr(1'b1, 8'h00);        // R8 counter stopped
        idle(200);
        wr(1'b1, 8'h01);        // R8 free running with wrap
        idle(300);
        irq_clr = 1'b1;         // R10 clear held
        idle(150);
        irq_clr = 1'b0;
        idle(1300);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge cpu_clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule